// File: doc/BRIEF.md
# Bus Termination and Address-Hold Generator

This block sits on the slave side of a two-phase pipelined bus. It watches the master's address-phase and data-phase strobes and produces two control signals. The first is the transfer acknowledge, which ends a data phase. The second is the address hold, which keeps the master's pending address phase from moving into the data phase.

Each transfer can be stretched by a wait count that is supplied on the cycle the transfer starts. An arbitration-busy input forces the hold at any time. A mode input selects single-clock operation or relaxed operation. In single-clock operation, a termination that arrives while an address phase is also pending carries a hold with it. The master therefore keeps its next address until the data bus has had one idle cycle.

Both outputs are derived in the same cycle from the registered transfer state and the present inputs. A zero-wait transfer is therefore acknowledged on its first data-phase cycle.

Top module: `bus_term_hold`

## Requirements
- R1: The wait count `wait_cfg` is sampled on the first data-phase cycle of a transfer. For a count of N, `term` is high on the (N+1)-th consecutive cycle of `data_act` and low on the N cycles before it.
- R2: If `data_act` stays high on the cycle after a termination, a new transfer starts on that cycle and samples `wait_cfg` again. With a count of 0 on every cycle, `term` is high on every cycle.
- R3: `term` is never high while `data_act` is low. If `data_act` falls before the termination, the pending count is dropped, and the next transfer uses its own freshly sampled count.
- R4: While `arb_busy` is high, `hold` is high in the same cycle, in either mode.
- R5: With `mode_1x` = 1, `hold` is high on every cycle where `term` and `addr_act` are both high.
- R6: With `mode_1x` = 1 and `arb_busy` low, `hold` stays low on a termination cycle where `addr_act` is low, and on any cycle without termination.
- R7: With `mode_1x` = 0, `hold` equals `arb_busy` on every cycle, including termination cycles with `addr_act` high.
- R8: A `hold` that is high during an active data phase does not change when that data phase terminates. The termination cycle is the same as it would be without the hold.
- R9: While `rst` is high, `term` and `hold` are low whatever the inputs are. A partly counted transfer is dropped, so the first transfer after reset counts from its own `wait_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_act | input | 1 | Master address-phase strobe |
| data_act | input | 1 | Master data-phase strobe |
| wait_cfg | input | WAIT_W | Wait cycles for the transfer starting this cycle |
| arb_busy | input | 1 | Bus busy with arbitration; forces hold |
| mode_1x | input | 1 | 1 = single-clock rule on, 0 = relaxed |
| term | output | 1 | Transfer acknowledge (termination) |
| hold | output | 1 | Address hold to the master |

## Verification
The bench runs wait counts of zero, one and several cycles, back to back and with an idle gap between them. A counter that is off by one would acknowledge a cycle early or late. A design that does not restart on continued strobes would miss the second acknowledge of a zero-wait burst. Aborting a data phase part way through the count catches a design that keeps a stale count or acknowledges with the strobe low. The hold is checked on termination cycles with and without a pending address, in both modes. A design that ignores the mode, or that gates the acknowledge with the hold, would show a wrong hold or a delayed termination.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic {
    MODE_RELAXED = 1'b0,
    MODE_1X      = 1'b1
  } mode_e;
endpackage

// File: rtl/bct_wait_timer.sv
module bct_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_act,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              term
);
  localparam logic [WAIT_W-1:0] ONE  = {{(WAIT_W-1){1'b0}}, 1'b1};
  localparam logic [WAIT_W-1:0] ZERO = '0;

  logic              busy;
  logic [WAIT_W-1:0] cnt;
  logic              at_zero;

  always_comb begin
    if (busy) at_zero = (cnt == ZERO);
    else      at_zero = (wait_cfg == ZERO);
  end

  assign term = !rst && data_act && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= ZERO;
    end else if (!data_act) begin
      busy <= 1'b0;
    end else if (at_zero) begin
      busy <= 1'b0;
    end else if (!busy) begin
      busy <= 1'b1;
      cnt  <= wait_cfg - ONE;
    end else begin
      cnt  <= cnt - ONE;
    end
  end
endmodule

// File: rtl/bct_hold_gen.sv
module bct_hold_gen (
  input  logic             rst,
  input  bct_pkg::mode_e   mode,
  input  logic             arb_busy,
  input  logic             addr_act,
  input  logic             term,
  output logic             hold
);
  logic rule_hold;

  always_comb begin
    rule_hold = 1'b0;
    if (mode == bct_pkg::MODE_1X) rule_hold = term && addr_act;
  end

  assign hold = !rst && (arb_busy || rule_hold);
endmodule

// File: rtl/bus_term_hold.sv
module bus_term_hold #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_act,
  input  logic              data_act,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              arb_busy,
  input  logic              mode_1x,
  output logic              term,
  output logic              hold
);
  bct_pkg::mode_e mode;
  logic           term_int;

  assign mode = mode_1x ? bct_pkg::MODE_1X : bct_pkg::MODE_RELAXED;

  bct_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .data_act (data_act),
    .wait_cfg (wait_cfg),
    .term     (term_int)
  );

  bct_hold_gen u_hold (
    .rst      (rst),
    .mode     (mode),
    .arb_busy (arb_busy),
    .addr_act (addr_act),
    .term     (term_int),
    .hold     (hold)
  );

  assign term = term_int;
endmodule

// File: rtl/bus_term_hold_chk.sv
module bus_term_hold_chk (
  input logic clk,
  input logic rst,
  input logic addr_act,
  input logic data_act,
  input logic arb_busy,
  input logic mode_1x,
  input logic term,
  input logic hold
);
  // R3
  a_r3_term_needs_data: assert property (@(posedge clk) disable iff (rst)
    term |-> data_act);

  // R4
  a_r4_arb_forces_hold: assert property (@(posedge clk) disable iff (rst)
    arb_busy |-> hold);

  // R5
  a_r5_hold_on_last_term: assert property (@(posedge clk) disable iff (rst)
    (mode_1x && term && addr_act) |-> hold);

  // R6
  a_r6_no_spurious_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_1x && !arb_busy && !(term && addr_act)) |-> !hold);

  // R7
  a_r7_relaxed_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_1x |-> (hold == arb_busy));

  // R9
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |-> (!term && !hold));
endmodule

bind bus_term_hold bus_term_hold_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr_act (addr_act),
  .data_act (data_act),
  .arb_busy (arb_busy),
  .mode_1x  (mode_1x),
  .term     (term),
  .hold     (hold)
);

// File: tb/sim_bus_term_hold.sv
`timescale 1ns/1ps
module sim_bus_term_hold;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_act = 1'b0;
  logic       data_act = 1'b0;
  logic [3:0] wait_cfg = 4'd0;
  logic       arb_busy = 1'b0;
  logic       mode_1x = 1'b1;
  logic       term;
  logic       hold;
  int         total = 0;
  int         bad = 0;
  logic       s_term;
  logic       s_hold;

  always #10 clk = ~clk;

  bus_term_hold #(.WAIT_W(4)) u0 (
    .clk(clk), .rst(rst), .addr_act(addr_act), .data_act(data_act),
    .wait_cfg(wait_cfg), .arb_busy(arb_busy), .mode_1x(mode_1x),
    .term(term), .hold(hold)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ds, input logic as, input logic ab, input logic [3:0] w);
    @(negedge clk);
    data_act = ds; addr_act = as; arb_busy = ab; wait_cfg = w;
    #2;
    s_term = term; s_hold = hold;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 4'd0);
  endtask

  // One transfer of N waits; term only on cycle N+1 (R1), optional hold (R8)
  task automatic xfer(input string req, input logic [3:0] n, input logic ab);
    for (int i = 0; i <= int'(n); i++) begin
      step(1'b1, 1'b0, ab, (i == 0) ? n : 4'd9);
      chk(req, $sformatf("term w=%0d cyc=%0d", n, i), s_term, (i == int'(n)));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 4'd0);
    chk("R9", "term in reset", s_term, 1'b0);
    chk("R9", "hold in reset", s_hold, 1'b0);
    rst = 1'b0;
    idle();
  endtask

  task automatic t_waits();
    xfer("R1", 4'd0, 1'b0); idle();
    xfer("R1", 4'd1, 1'b0); idle();
    xfer("R1", 4'd4, 1'b0); idle();
    xfer("R1", 4'd15, 1'b0); idle();
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 1'b0, 4'd0);
      chk("R2", "zero-wait burst term", s_term, 1'b1);
    end
    xfer("R2", 4'd2, 1'b0);
    xfer("R2", 4'd1, 1'b0);
    idle();
  endtask

  task automatic t_abort();
    step(1'b1, 1'b0, 1'b0, 4'd5);
    step(1'b1, 1'b0, 1'b0, 4'd9);
    idle();
    chk("R3", "term with data low", s_term, 1'b0);
    step(1'b0, 1'b1, 1'b0, 4'd0);
    chk("R3", "term with data low, addr high", s_term, 1'b0);
    xfer("R3", 4'd1, 1'b0);
    idle();
  endtask

  task automatic t_modes();
    mode_1x = 1'b1;
    step(1'b0, 1'b1, 1'b1, 4'd0);
    chk("R4", "arb hold 1x", s_hold, 1'b1);
    step(1'b1, 1'b1, 1'b0, 4'd1);
    chk("R6", "no hold while waiting", s_hold, 1'b0);
    step(1'b1, 1'b1, 1'b0, 4'd9);
    chk("R5", "term with addr", s_term, 1'b1);
    chk("R5", "hold on last term", s_hold, 1'b1);
    step(1'b1, 1'b0, 1'b0, 4'd0);
    chk("R6", "term without addr", s_term, 1'b1);
    chk("R6", "no hold without addr", s_hold, 1'b0);
    idle();
    mode_1x = 1'b0;
    step(1'b1, 1'b1, 1'b0, 4'd0);
    chk("R7", "relaxed term", s_term, 1'b1);
    chk("R7", "relaxed no hold", s_hold, 1'b0);
    step(1'b1, 1'b1, 1'b1, 4'd0);
    chk("R4", "arb hold relaxed", s_hold, 1'b1);
    chk("R7", "relaxed term under arb", s_term, 1'b1);
    idle();
    mode_1x = 1'b1;
  endtask

  task automatic t_hold_no_stall();
    xfer("R8", 4'd3, 1'b1);
    chk("R8", "hold during data phase", s_hold, 1'b1);
    idle();
  endtask

  task automatic t_reset_mid();
    step(1'b1, 1'b0, 1'b0, 4'd6);
    step(1'b1, 1'b0, 1'b0, 4'd9);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 4'd0);
    chk("R9", "term in mid reset", s_term, 1'b0);
    chk("R9", "hold in mid reset", s_hold, 1'b0);
    rst = 1'b0;
    xfer("R9", 4'd1, 1'b0);
    idle();
  endtask

  initial begin
    t_reset();
    t_waits();
    t_back_to_back();
    t_abort();
    t_modes();
    t_hold_no_stall();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule